// File: doc/BRIEF.md
# Processor Debug Mode Controller

This controller decides whether a processor core runs normally or sits frozen in debug mode. Exception and event requests set bits in a 16-bit cause register. When a cause bit is set whose bit in the programmable enable mask is also set, the core enters debug mode. At that point the controller does four things:

- It raises a registered freeze output.
- It pulses the enable that captures the saved program counter and status.
- It clears the external interrupt enable.
- It steers every instruction fetch to the debug port. Data accesses keep their own addresses and are not affected.

In debug mode, exceptions are not vectored. Each one sets its cause bit and raises a one-cycle report pulse. In that same cycle the fetch is held back, so the report always comes before the next fetch. Breakpoint and watchpoint sources are ignored. A return strobe leaves debug mode unless an enabled cause bit is still pending, in which case the core stays frozen.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, freeze_o, ee_o, err_o and save_we_o are 0, cause_o is 0 and the enable mask is 0.
- R2: In normal mode, a cycle in which a recognised cause bit (new or already held) has its mask bit set raises save_we_o in that cycle. freeze_o goes high on the following clock edge.
- R3: fetch_dbg_o equals fetch_req_i while freeze_o is high, and is 0 otherwise.
- R4: The entry cycle clears ee_o at the next edge, even if ee_set_i is high in that cycle. Otherwise ee_set_i sets ee_o and ee_clr_i clears it at the next edge.
- R5: An exception recognised in debug mode sets its cause bit at the next edge and drives err_o high in that same cycle only. save_we_o stays 0.
- R6: fetch_vld_o equals fetch_req_i except in a cycle where err_o is high, when it is 0.
- R7: In debug mode, event bits selected by parameter BP_MASK (default bits 0 and 1, the breakpoint and watchpoint sources) are ignored. They set no cause bit and give no err_o.
- R8: ext_irq_i is a level request on cause bit EXT_BIT (default 15), recognised on every clock while ee_o is 1. In debug mode the hardware never clears ee_o.
- R9: In debug mode, rfi_i with no pending enabled cause bit drives freeze_o low at the next edge.
- R10: In debug mode, rfi_i while a held cause bit has its mask bit set keeps freeze_o high. This holds even if cause_rd_i clears that bit in the same cycle.
- R11: If rfi_i and a new event with its mask bit set arrive in the same cycle, the event wins and freeze_o stays high.
- R12: cause_rd_i clears the cause register at the next edge. Bits recognised in the same cycle are still set.
- R13: mask_we_i loads mask_i into the enable mask at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 16 | Exception and event requests, one per cause bit |
| ext_irq_i | input | 1 | External interrupt level |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| cause_rd_i | input | 1 | Cause register read strobe, clears on read |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_i | input | 16 | Enable mask write data |
| ee_set_i | input | 1 | Software sets interrupt enable |
| ee_clr_i | input | 1 | Software clears interrupt enable |
| fetch_req_i | input | 1 | Instruction fetch request |
| cause_o | output | 16 | Cause register |
| ee_o | output | 1 | External interrupt enable |
| freeze_o | output | 1 | Debug mode (freeze) indication |
| fetch_dbg_o | output | 1 | Steer current fetch to debug port |
| fetch_vld_o | output | 1 | Fetch may issue this cycle |
| err_o | output | 1 | One-cycle exception report in debug mode |
| save_we_o | output | 1 | Save register update enable |

## Verification
The hardest case to reach is the level-sensitive external interrupt while the core is frozen. Entry always clears the enable, so the bench first enters debug mode on the interrupt itself. It then sets the enable from software while the level is held. The check is that err_o fires on every following cycle and that ee_o survives. The bench also forces a return while a cause bit is still pending, and separately a return in the same cycle as a fresh enabled event. In both cases freeze_o must not drop.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;
  localparam int unsigned CAUSE_W = 16;
  typedef enum logic {MODE_RUN = 1'b0, MODE_DBG = 1'b1} mode_e;
endpackage

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] BP_MASK = 'h3,
  parameter int unsigned EXT_BIT = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dbg_i,
  input  logic         ee_i,
  input  logic [W-1:0] event_i,
  input  logic         ext_irq_i,
  input  logic         rd_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] cause_o,
  output logic         rec_any_o,
  output logic         pend_o
);
  logic [W-1:0] cause_q, mask_q, rec;

  always_comb begin
    rec = event_i & ~(dbg_i ? BP_MASK : '0);
    rec[EXT_BIT] = rec[EXT_BIT] | (ext_irq_i & ee_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (rd_i ? '0 : cause_q) | rec;  // new events win over clear
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign cause_o   = cause_q;
  assign rec_any_o = |rec;
  assign pend_o    = |((cause_q | rec) & mask_q);

  AST_BP_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |=> ((cause_q & ~$past(cause_q) & BP_MASK) == '0));  // R7
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rec_any_o) |=> (cause_q == '0));  // R12
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rec_any_i,
  input  logic pend_i,
  input  logic rfi_i,
  input  logic ee_set_i,
  input  logic ee_clr_i,
  output logic dbg_o,
  output logic ee_o,
  output logic err_o,
  output logic save_we_o
);
  mode_e mode_q, mode_d;
  logic  ee_q, enter;

  assign enter = (mode_q == MODE_RUN) && pend_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: if (pend_i) mode_d = MODE_DBG;
      MODE_DBG: if (rfi_i && !pend_i) mode_d = MODE_RUN;  // pending cause forces re-entry
      default:  mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      ee_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (enter)         ee_q <= 1'b0;
      else if (ee_set_i) ee_q <= 1'b1;
      else if (ee_clr_i) ee_q <= 1'b0;
    end
  end

  assign dbg_o     = (mode_q == MODE_DBG);
  assign ee_o      = ee_q;
  assign err_o     = dbg_o && rec_any_i;
  assign save_we_o = enter;

  AST_ENTER_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && pend_i) |=> (mode_q == MODE_DBG));  // R2
  AST_EE_CLR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && pend_i) |=> !ee_q);  // R4
  AST_EE_HOLD_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DBG && ee_q && !ee_clr_i) |=> ee_q);  // R8
  AST_RFI_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DBG && rfi_i && !pend_i) |=> (mode_q == MODE_RUN));  // R9
  AST_RFI_REENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DBG && rfi_i && pend_i) |=> (mode_q == MODE_DBG));  // R10
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int unsigned W = CAUSE_W,
  parameter logic [W-1:0] BP_MASK = 'h3,
  parameter int unsigned EXT_BIT = W - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic         ext_irq_i,
  input  logic         rfi_i,
  input  logic         cause_rd_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_i,
  input  logic         ee_set_i,
  input  logic         ee_clr_i,
  input  logic         fetch_req_i,
  output logic [W-1:0] cause_o,
  output logic         ee_o,
  output logic         freeze_o,
  output logic         fetch_dbg_o,
  output logic         fetch_vld_o,
  output logic         err_o,
  output logic         save_we_o
);
  logic dbg, ee, rec_any, pend, err;

  dbg_cause_reg #(.W(W), .BP_MASK(BP_MASK), .EXT_BIT(EXT_BIT)) i_cause (
    .clk_i, .rst_ni, .dbg_i(dbg), .ee_i(ee), .event_i, .ext_irq_i,
    .rd_i(cause_rd_i), .mask_we_i, .mask_i, .cause_o,
    .rec_any_o(rec_any), .pend_o(pend)
  );

  dbg_mode_fsm i_fsm (
    .clk_i, .rst_ni, .rec_any_i(rec_any), .pend_i(pend), .rfi_i,
    .ee_set_i, .ee_clr_i, .dbg_o(dbg), .ee_o(ee), .err_o(err), .save_we_o
  );

  assign freeze_o    = dbg;
  assign ee_o        = ee;
  assign err_o       = err;
  assign fetch_dbg_o = fetch_req_i && dbg;
  assign fetch_vld_o = fetch_req_i && !err;  // report precedes the next fetch

  AST_FETCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !fetch_vld_o);  // R6
endmodule

// File: tb/test_dbg_mode_ctrl.sv
module test_dbg_mode_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] event_i = '0, mask_i = '0;
  logic         ext_irq_i = 0, rfi_i = 0, cause_rd_i = 0, mask_we_i = 0;
  logic         ee_set_i = 0, ee_clr_i = 0, fetch_req_i = 0;
  logic [W-1:0] cause_o;
  logic         ee_o, freeze_o, fetch_dbg_o, fetch_vld_o, err_o, save_we_o;

  always #10 clk = ~clk;  // 50 MHz

  dbg_mode_ctrl i_dbg_mode_ctrl (
    .clk_i(clk), .rst_ni, .event_i, .ext_irq_i, .rfi_i, .cause_rd_i,
    .mask_we_i, .mask_i, .ee_set_i, .ee_clr_i, .fetch_req_i,
    .cause_o, .ee_o, .freeze_o, .fetch_dbg_o, .fetch_vld_o, .err_o, .save_we_o
  );

  typedef struct {
    logic         frz;
    logic [W-1:0] cause;
    logic         ee, err, save, fdbg, fvld;
    string        tag;
  } item_t;

  item_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one cycle; expectations are the outputs seen during this cycle
  task automatic drv(input logic [W-1:0] ev, input logic ext, rfi, rd, fr, es, ec,
                     input logic xfrz, input logic [W-1:0] xcause,
                     input logic xee, xerr, xsave, input string tag);
    item_t it;
    @(negedge clk);
    event_i = ev; ext_irq_i = ext; rfi_i = rfi; cause_rd_i = rd;
    fetch_req_i = fr; ee_set_i = es; ee_clr_i = ec; mask_we_i = 0;
    it.frz = xfrz; it.cause = xcause; it.ee = xee; it.err = xerr; it.save = xsave;
    it.fdbg = fr & xfrz;   // R3
    it.fvld = fr & ~xerr;  // R6
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "freeze_o",    W'(freeze_o),    W'(it.frz));
        chk(it.tag, "cause_o",     cause_o,         it.cause);
        chk(it.tag, "ee_o",        W'(ee_o),        W'(it.ee));
        chk(it.tag, "err_o",       W'(err_o),       W'(it.err));
        chk(it.tag, "save_we_o",   W'(save_we_o),   W'(it.save));
        chk(it.tag, "fetch_dbg_o", W'(fetch_dbg_o), W'(it.fdbg));
        chk(it.tag, "fetch_vld_o", W'(fetch_vld_o), W'(it.fvld));
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    //   ev       ext rfi rd fr es ec | frz cause     ee err save
    drv(16'h0000, 0, 0, 0, 1, 0, 0,    0, 16'h0000, 0, 0, 0, "R1");
    @(negedge clk);  // mask write (R13) plus ee set
    mask_we_i = 1; mask_i = 16'h8014; ee_set_i = 1;
    @(negedge clk);
    mask_we_i = 0; ee_set_i = 0;
    drv(16'h0008, 0, 0, 0, 1, 0, 0,    0, 16'h0000, 1, 0, 0, "R13");  // unmasked bit3: no entry
    drv(16'h0000, 0, 0, 1, 0, 0, 0,    0, 16'h0008, 1, 0, 0, "R12");  // read clears
    drv(16'h0004, 0, 0, 0, 1, 0, 0,    0, 16'h0000, 1, 0, 1, "R2");   // masked bit2: entry
    drv(16'h0000, 0, 0, 0, 1, 0, 0,    1, 16'h0004, 0, 0, 0, "R4");   // frozen, ee cleared
    drv(16'h0001, 0, 0, 0, 1, 0, 0,    1, 16'h0004, 0, 0, 0, "R7");   // breakpoint ignored
    drv(16'h0002, 0, 0, 0, 1, 0, 0,    1, 16'h0004, 0, 0, 0, "R7");   // watchpoint ignored
    drv(16'h0020, 0, 0, 0, 1, 0, 0,    1, 16'h0004, 0, 1, 0, "R5");   // exception in debug
    drv(16'h0000, 0, 0, 0, 1, 0, 0,    1, 16'h0024, 0, 0, 0, "R5");   // one cycle only
    drv(16'h0000, 0, 1, 0, 0, 0, 0,    1, 16'h0024, 0, 0, 0, "R10");  // rfi with pending
    drv(16'h0000, 0, 1, 1, 0, 0, 0,    1, 16'h0024, 0, 0, 0, "R10");  // rfi + read: still pending
    drv(16'h0010, 0, 1, 0, 1, 0, 0,    1, 16'h0000, 0, 1, 0, "R11");  // rfi + new masked event
    drv(16'h0000, 0, 0, 1, 0, 0, 0,    1, 16'h0010, 0, 0, 0, "R11");
    drv(16'h0000, 0, 1, 0, 0, 0, 0,    1, 16'h0000, 0, 0, 0, "R9");   // clean exit
    drv(16'h0000, 0, 0, 0, 1, 0, 0,    0, 16'h0000, 0, 0, 0, "R9");
    drv(16'h0000, 0, 0, 0, 0, 1, 0,    0, 16'h0000, 0, 0, 0, "R4");   // ee set in normal
    drv(16'h0000, 1, 0, 0, 1, 1, 0,    0, 16'h0000, 1, 0, 1, "R8");   // ext entry, entry beats set
    drv(16'h0000, 1, 0, 0, 1, 1, 0,    1, 16'h8000, 0, 0, 0, "R4");   // ee 0: ext not seen
    drv(16'h0000, 1, 0, 1, 1, 0, 0,    1, 16'h8000, 1, 1, 0, "R8");   // level seen, wins read
    drv(16'h0000, 1, 0, 0, 1, 0, 0,    1, 16'h8000, 1, 1, 0, "R8");   // again, ee kept
    drv(16'h0000, 0, 0, 1, 0, 0, 1,    1, 16'h8000, 1, 0, 0, "R8");
    drv(16'h0000, 0, 1, 0, 1, 0, 0,    1, 16'h0000, 0, 0, 0, "R9");
    drv(16'h0000, 0, 0, 0, 1, 0, 0,    0, 16'h0000, 0, 0, 0, "R3");
    @(negedge clk);
    event_i = '0; rfi_i = 0; cause_rd_i = 0; fetch_req_i = 0; ext_irq_i = 0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule